// File: doc/BRIEF.md
# Reconfigurable Precision Recursive Multiplier

This block multiplies two operands of 2·HALF_W bits. Its datapath is built recursively: a full product is assembled from four half-width multipliers, and each of those is split the same way until a leaf width is reached. A 2-bit mode, sampled with the operands, re-assigns those four half-width multipliers. The modes are:

- one full-width product;
- one narrow product of the low halves;
- a narrow product computed twice and compared;
- two independent narrow products delivered together.

Operands enter through a valid/ready stream and results leave through a valid/ready stream. An operation is accepted on a rising edge where `in_valid` and `in_ready` are both high. A result is consumed on an edge where `out_valid` and `out_ready` are both high. While a result waits (`out_valid` high, `out_ready` low), the whole pipeline freezes and `in_ready` drops. The error flag travels with its result. A new mode applies only to the operation it was accepted with.

Top module: `rpm_mult`

## Requirements
- R1: Mode 2'b00 (double) gives `out_result` = `in_a` × `in_b` as a full 4·HALF_W-bit unsigned product.
- R2: Mode 2'b01 (single) gives the low-half product a[HALF_W-1:0] × b[HALF_W-1:0] in the low 2·HALF_W bits. The upper 2·HALF_W bits are zero, and the high operand halves have no effect.
- R3: Mode 2'b10 (checked single) gives the same result as R2. Two separate half-width multipliers compute the low-half product, and `out_err` is raised with the result only when they disagree.
- R4: Mode 2'b11 (dual) gives low-half product in bits [2·HALF_W-1:0] and high-half product a[2·HALF_W-1:HALF_W] × b[2·HALF_W-1:HALF_W] in bits [4·HALF_W-1:2·HALF_W].
- R5: With `out_ready` held high, an operation presented in cycle c and accepted at the end of it shows `out_valid` and its result in cycle c+2, and not in cycle c+1.
- R6: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_result` and `out_err` hold their values, and `in_ready` is low.
- R7: `in_ready` is high in every cycle where `out_valid` is low or `out_ready` is high.
- R8: The mode is captured with each operation, so back-to-back operations in different modes each produce their own mode's result, in order.
- R9: After reset, `out_valid` is low and `in_ready` is high.
- R10: `out_err` is never high with a result of a mode other than 2'b10.
- R11: With `out_ready` high, one operation is accepted per cycle, and results leave in acceptance order with no loss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_a | input | 2·HALF_W | Multiplicand |
| in_b | input | 2·HALF_W | Multiplier |
| in_mode | input | 2 | Precision mode, sampled on acceptance |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 4·HALF_W | Product or packed pair of products |
| out_err | output | 1 | Replica mismatch for a checked single operation |

## Verification
The assertions check stall behaviour on every cycle: the result and flag are held, and `in_ready` is low under a stall. They also keep a shadow record of each operation's mode and validity, which lets them check that `out_valid` timing follows acceptances, that the upper half is zero for narrow modes, and that the error flag only accompanies checked operations. The product values in all four modes come only from the bench's sweeps. The bench runs a reduced 8-bit configuration and compares against arithmetic. The exact two-cycle latency, mode changes between back-to-back operations, and draining order after a stall are also shown only by the bench's directed scenarios.

// File: rtl/rpm_pkg.sv
package rpm_pkg;
  typedef enum logic [1:0] {
    RPM_DOUBLE = 2'b00,
    RPM_SINGLE = 2'b01,
    RPM_SAFE   = 2'b10,
    RPM_DUAL   = 2'b11
  } rpm_mode_e;
endpackage

// File: rtl/rpm_rec_mult.sv
// Recursive unsigned multiplier: splits into four half-width products
// until the leaf width is reached.
module rpm_rec_mult #(
  parameter int W      = 16,
  parameter int LEAF_W = 8
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  output logic [2*W-1:0] p
);
  generate
    if (W <= LEAF_W || (W % 2) != 0) begin : g_leaf
      assign p = a * b;
    end else begin : g_split
      localparam int H = W / 2;
      logic [2*H-1:0] p_ll, p_lh, p_hl, p_hh;
      logic [2*W-1:0] ext_ll, ext_mid, ext_hh;

      rpm_rec_mult #(.W(H), .LEAF_W(LEAF_W)) u_ll (.a(a[H-1:0]), .b(b[H-1:0]), .p(p_ll));
      rpm_rec_mult #(.W(H), .LEAF_W(LEAF_W)) u_lh (.a(a[H-1:0]), .b(b[W-1:H]), .p(p_lh));
      rpm_rec_mult #(.W(H), .LEAF_W(LEAF_W)) u_hl (.a(a[W-1:H]), .b(b[H-1:0]), .p(p_hl));
      rpm_rec_mult #(.W(H), .LEAF_W(LEAF_W)) u_hh (.a(a[W-1:H]), .b(b[W-1:H]), .p(p_hh));

      always_comb begin
        ext_ll  = {{(2*W-2*H){1'b0}}, p_ll};
        ext_mid = ({{(2*W-2*H){1'b0}}, p_lh} + {{(2*W-2*H){1'b0}}, p_hl}) << H;
        ext_hh  = {p_hh, {(2*W-2*H){1'b0}}};
        p       = ext_hh + ext_mid + ext_ll;
      end
    end
  endgenerate
endmodule

// File: rtl/rpm_route.sv
// Steers operand halves to the four base multipliers per mode; unused
// multipliers get zero operands.
module rpm_route
  import rpm_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] a,
  input  logic [2*HALF_W-1:0] b,
  input  rpm_mode_e           mode,
  output logic [HALF_W-1:0]   ll_a, ll_b,
  output logic [HALF_W-1:0]   lh_a, lh_b,
  output logic [HALF_W-1:0]   hl_a, hl_b,
  output logic [HALF_W-1:0]   hh_a, hh_b
);
  localparam int H = HALF_W;
  logic [H-1:0] a_lo, a_hi, b_lo, b_hi;

  always_comb begin
    a_lo = a[H-1:0];
    a_hi = a[2*H-1:H];
    b_lo = b[H-1:0];
    b_hi = b[2*H-1:H];
    ll_a = a_lo;
    ll_b = b_lo;
    lh_a = '0; lh_b = '0;
    hl_a = '0; hl_b = '0;
    hh_a = '0; hh_b = '0;
    unique case (mode)
      RPM_DOUBLE: begin
        lh_a = a_lo; lh_b = b_hi;
        hl_a = a_hi; hl_b = b_lo;
        hh_a = a_hi; hh_b = b_hi;
      end
      RPM_SAFE: begin
        hh_a = a_lo; hh_b = b_lo;
      end
      RPM_DUAL: begin
        hh_a = a_hi; hh_b = b_hi;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rpm_combine.sv
// Sums the four registered partial products and compares replicas.
module rpm_combine
  import rpm_pkg::*;
#(
  parameter int HALF_W = 16
) (
  input  logic [2*HALF_W-1:0] pp_ll,
  input  logic [2*HALF_W-1:0] pp_lh,
  input  logic [2*HALF_W-1:0] pp_hl,
  input  logic [2*HALF_W-1:0] pp_hh,
  input  rpm_mode_e           mode,
  output logic [4*HALF_W-1:0] sum,
  output logic                mismatch
);
  localparam int PW = 2 * HALF_W;
  localparam int RW = 4 * HALF_W;
  logic [RW-1:0] hi_part, mid_part, lo_part;

  always_comb begin
    hi_part  = (mode == RPM_SAFE) ? '0 : {pp_hh, {PW{1'b0}}};
    mid_part = ({{(RW-PW){1'b0}}, pp_lh} + {{(RW-PW){1'b0}}, pp_hl}) << HALF_W;
    lo_part  = {{(RW-PW){1'b0}}, pp_ll};
    sum      = hi_part + mid_part + lo_part;
    mismatch = (mode == RPM_SAFE) && (pp_ll != pp_hh);
  end
endmodule

// File: rtl/rpm_mult.sv
module rpm_mult
  import rpm_pkg::*;
#(
  parameter int HALF_W = 16,
  parameter int LEAF_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  output logic                  in_ready,
  input  logic [2*HALF_W-1:0]   in_a,
  input  logic [2*HALF_W-1:0]   in_b,
  input  logic [1:0]            in_mode,
  output logic                  out_valid,
  input  logic                  out_ready,
  output logic [4*HALF_W-1:0]   out_result,
  output logic                  out_err
);
  localparam int PW = 2 * HALF_W;
  localparam int RW = 4 * HALF_W;
  localparam int NB = 4;

  rpm_mode_e mode_in;
  logic      advance;
  logic [HALF_W-1:0] op_a [NB];
  logic [HALF_W-1:0] op_b [NB];
  logic [PW-1:0]     prod [NB];

  logic          s1_valid;
  rpm_mode_e     s1_mode;
  logic [PW-1:0] s1_pp [NB];

  logic [RW-1:0] sum_w;
  logic          mismatch_w;

  assign mode_in  = rpm_mode_e'(in_mode);
  assign advance  = !out_valid || out_ready;
  assign in_ready = advance;

  // index 0: low x low, 1: low x high, 2: high x low, 3: high x high
  rpm_route #(.HALF_W(HALF_W)) u_route (
    .a(in_a), .b(in_b), .mode(mode_in),
    .ll_a(op_a[0]), .ll_b(op_b[0]),
    .lh_a(op_a[1]), .lh_b(op_b[1]),
    .hl_a(op_a[2]), .hl_b(op_b[2]),
    .hh_a(op_a[3]), .hh_b(op_b[3])
  );

  generate
    for (genvar gi = 0; gi < NB; gi++) begin : g_base
      rpm_rec_mult #(.W(HALF_W), .LEAF_W(LEAF_W)) u_mul (
        .a(op_a[gi]), .b(op_b[gi]), .p(prod[gi])
      );
      always_ff @(posedge clk) begin
        if (!rst_n)       s1_pp[gi] <= '0;
        else if (advance) s1_pp[gi] <= prod[gi];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mode  <= RPM_DOUBLE;
    end else if (advance) begin
      s1_valid <= in_valid;
      s1_mode  <= mode_in;
    end
  end

  rpm_combine #(.HALF_W(HALF_W)) u_comb (
    .pp_ll(s1_pp[0]), .pp_lh(s1_pp[1]), .pp_hl(s1_pp[2]), .pp_hh(s1_pp[3]),
    .mode(s1_mode), .sum(sum_w), .mismatch(mismatch_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_result <= '0;
      out_err    <= 1'b0;
    end else if (advance) begin
      out_valid  <= s1_valid;
      out_result <= sum_w;
      out_err    <= mismatch_w;
    end
  end
endmodule

// File: rtl/rpm_mult_chk.sv
module rpm_mult_chk #(
  parameter int HALF_W = 16
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic [1:0]          in_mode,
  input logic                out_valid,
  input logic                out_ready,
  input logic [4*HALF_W-1:0] out_result,
  input logic                out_err
);
  logic       sh_go;
  logic       sh1_v, sh2_v;
  logic [1:0] sh1_m, sh2_m;

  assign sh_go = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh1_v <= 1'b0; sh2_v <= 1'b0;
      sh1_m <= 2'b00; sh2_m <= 2'b00;
    end else if (sh_go) begin
      sh1_v <= in_valid && in_ready;
      sh1_m <= in_mode;
      sh2_v <= sh1_v;
      sh2_m <= sh1_m;
    end
  end

  // R6: stalled result and flag hold, input side blocked
  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_result) && $stable(out_err));
  a_r6_block: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R5: results appear exactly where accepted operations land
  a_r5_timing: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == sh2_v);
  // R2: narrow modes leave the upper half clear
  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && (sh2_m == 2'b01 || sh2_m == 2'b10) |-> out_result[4*HALF_W-1:2*HALF_W] == '0);
  // R10: error only with checked operations
  a_r10_err_mode: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> sh2_m == 2'b10);
endmodule

bind rpm_mult rpm_mult_chk #(.HALF_W(HALF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_mode(in_mode), .out_valid(out_valid), .out_ready(out_ready),
  .out_result(out_result), .out_err(out_err)
);

// File: tb/rpm_mult_test.sv
module rpm_mult_test;
  localparam int HW = 4;
  localparam int OW = 2 * HW;
  localparam int RW = 4 * HW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic [OW-1:0] in_a = '0;
  logic [OW-1:0] in_b = '0;
  logic [1:0]    in_mode = 2'b00;
  logic          out_valid;
  logic          out_ready = 1'b1;
  logic [RW-1:0] out_result;
  logic          out_err;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit stall_on = 1'b0;
  bit done = 1'b0;
  logic [RW-1:0] expq [$];

  always #2.5 clk = ~clk;

  rpm_mult #(.HALF_W(HW), .LEAF_W(2)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_mode(in_mode), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_err(out_err)
  );

  function automatic logic [RW-1:0] model(logic [OW-1:0] a, logic [OW-1:0] b, logic [1:0] m);
    logic [OW-1:0] lo, hi;
    lo = OW'(a[HW-1:0]) * OW'(b[HW-1:0]);
    hi = OW'(a[OW-1:HW]) * OW'(b[OW-1:HW]);
    case (m)
      2'b00:   return RW'(a) * RW'(b);
      2'b11:   return {hi, lo};
      default: return {{OW{1'b0}}, lo};
    endcase
  endfunction

  function automatic string req_of(logic [1:0] m);
    case (m)
      2'b00: return "R1";
      2'b01: return "R2";
      2'b10: return "R3";
      default: return "R4";
    endcase
  endfunction

  task automatic check(bit ok, string req, logic [RW-1:0] act, logic [RW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called 1 time unit after a negedge: consume a result if handshaking.
  task automatic observe();
    logic [RW-1:0] e;
    if (out_valid && out_ready) begin
      if (expq.size() == 0) begin
        check(1'b0, "R11 unexpected result", out_result, '0);
      end else begin
        e = expq.pop_front();
        check(out_result == e, "R11/R8 result order and value", out_result, e);
        check(out_err == 1'b0, "R10/R3 err flag", RW'(out_err), '0);
      end
    end
  endtask

  task automatic set_ready();
    out_ready = stall_on ? ((cyc % 5) != 2) : 1'b1;
    cyc++;
  endtask

  task automatic send(logic [OW-1:0] a, logic [OW-1:0] b, logic [1:0] m);
    bit acc;
    in_a = a; in_b = b; in_mode = m; in_valid = 1'b1;
    do begin
      set_ready();
      #1;
      acc = in_ready;
      if (!out_valid || out_ready)
        check(in_ready == 1'b1, "R7 in_ready", RW'(in_ready), RW'(1));
      if (acc) expq.push_back(model(a, b, m));
      observe();
      @(negedge clk);
    end while (!acc);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    int guard = 0;
    while (expq.size() != 0 && guard < 100) begin
      set_ready();
      #1;
      observe();
      @(negedge clk);
      guard++;
    end
    check(expq.size() == 0, "R11 drain", RW'(expq.size()), '0);
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [RW-1:0] e1, e2, held;
    repeat (3) @(negedge clk);
    #1;
    // R9: reset state
    check(out_valid == 1'b0, "R9 out_valid in reset", RW'(out_valid), '0);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R9 out_valid after reset", RW'(out_valid), '0);
    check(in_ready == 1'b1, "R9 in_ready after reset", RW'(in_ready), RW'(1));

    // R5: exact latency, mode 11 (R4)
    in_a = 8'hB7; in_b = 8'h9D; in_mode = 2'b11; in_valid = 1'b1;
    e1 = model(8'hB7, 8'h9D, 2'b11);
    @(negedge clk);
    in_valid = 1'b0;
    #1;
    check(out_valid == 1'b0, "R5 not valid in cycle c+1", RW'(out_valid), '0);
    @(negedge clk);
    #1;
    check(out_valid == 1'b1, "R5 valid in cycle c+2", RW'(out_valid), RW'(1));
    check(out_result == e1, "R4 dual product", out_result, e1);
    @(negedge clk);

    // R6: back-pressure with mixed modes (R8)
    out_ready = 1'b0;
    in_a = 8'hE3; in_b = 8'h5A; in_mode = 2'b11; in_valid = 1'b1;
    e1 = model(8'hE3, 8'h5A, 2'b11);
    @(negedge clk);
    in_a = 8'hF1; in_b = 8'hC6; in_mode = 2'b00;
    e2 = model(8'hF1, 8'hC6, 2'b00);
    @(negedge clk);
    in_valid = 1'b0;
    in_a = 8'h00; in_mode = 2'b01;
    #1;
    check(out_valid == 1'b1, "R6 valid while stalled", RW'(out_valid), RW'(1));
    check(in_ready == 1'b0, "R6 in_ready low on stall", RW'(in_ready), '0);
    check(out_result == e1, "R8 first op keeps its mode", out_result, e1);
    held = out_result;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      #1;
      check(out_valid == 1'b1 && out_result == held, "R6 result held", out_result, held);
      check(in_ready == 1'b0, "R6 in_ready held low", RW'(in_ready), '0);
    end
    out_ready = 1'b1;
    #1;
    check(in_ready == 1'b1, "R7 in_ready with out_ready", RW'(in_ready), RW'(1));
    @(negedge clk);
    #1;
    check(out_valid == 1'b1 && out_result == e2, "R8 second op double mode", out_result, e2);
    @(negedge clk);
    #1;
    check(out_valid == 1'b0, "R11 pipeline empty", RW'(out_valid), '0);
    @(negedge clk);

    // Sweep: every mode, every a, spread of b, back-to-back (R1-R4, R11)
    for (int m = 0; m < 4; m++)
      for (int a = 0; a < 256; a++)
        for (int b = 0; b < 256; b += 17)
          send(OW'(a), OW'(b), 2'(m));
    drain();

    // Mixed modes with irregular back-pressure (R6, R8)
    stall_on = 1'b1;
    for (int i = 0; i < 3000; i++)
      send(OW'(i * 37 + 11), OW'(i * 101 + 3), 2'(i % 4));
    drain();

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule